// File: doc/BRIEF.md
# Sleep and Wake Clock Controller

This controller runs from the always-on 32 kHz oscillator and decides which clock feeds the rest of the chip. After power-on it keeps the low-frequency clock gated until an internal counter shows that the oscillator has had time to settle. Once the processor is running on that slow clock, it can switch the system onto the high-frequency reference clock from the radio (12 to 32 MHz). To do this, it raises a select line, and the controller answers by selecting the reference.

Software requests sleep by setting a power-down-enable bit. The controller then drops its request for the reference clock and falls back to the slow clock. Only logic on the 32 kHz domain keeps running during sleep. Sleep ends when the internal wake timer expires or when any of the external wake lines is asserted. On wake, the controller requests the reference again and waits a settle interval. It then returns to slow-clock running, and the processor has to select the reference again. A cause register records what woke the chip, and software clears it by writing ones.

Top module: `slpwk_ctrl`

## Requirements
- R1: While `rst_n` is low, `lf_clk_en_o`, `ref_req_o`, `src_sel_hf_o` and `pde_o` are 0 and `wake_stat_o` is all zeros.
- R2: `lf_clk_en_o` first reads 1 after exactly STABLE_CYCLES+2 rising edges of `clk_lf` following the release of `rst_n`. Two of these edges are taken by reset synchronisation. After that, the output stays 1 until the next reset.
- R3: `ref_req_o` is 1 in slow-clock run, reference run and wake settle. It is 0 during the stabilisation wait and during sleep. `src_sel_hf_o` is never 1 while `ref_req_o` is 0.
- R4: In slow-clock run, `sel_hf_i` sampled 1 when it was 0 on the previous edge sets `src_sel_hf_o` to 1 after that edge. In reference run, `sel_hf_i` sampled 0 returns `src_sel_hf_o` to 0 after that edge.
- R5: A `pde_set_i` pulse in either run state sets `pde_o` on the next edge. On the edge after that, the block enters sleep: `ref_req_o`, `src_sel_hf_o` and `pde_o` all become 0. A pending sleep takes priority over a select change in the same cycle.
- R6: In sleep, `wake_tmr_i` or any bit of `wake_ext_i` sampled high moves the block to wake settle on that edge, so `ref_req_o` becomes 1 with `src_sel_hf_o` still 0.
- R7: The block stays in wake settle for SETTLE_CYCLES edges and then returns to slow-clock run. It selects the reference only on a new rising `sel_hf_i` seen in slow-clock run. A level held high through sleep does not reselect it.
- R8: `wake_stat_o` bit 0 records the timer and bit k+1 records `wake_ext_i[k]`. The bits are set from the inputs present on the edge that leaves sleep. Wake inputs in any other state leave `wake_stat_o` unchanged.
- R9: A cycle with `stat_clr_we_i` high clears the `wake_stat_o` bits where `stat_clr_mask_i` is 1 and keeps the other bits. If a capture and a clear hit the same bit on the same edge, the capture wins.
- R10: `pde_set_i` is ignored in sleep, wake settle and the stabilisation wait, and `pde_o` is 0 after any wake. The block therefore stays in slow-clock run after waking until software requests sleep again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Always-on 32 kHz clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sel_hf_i | input | 1 | Processor request to run on the reference clock (level) |
| pde_set_i | input | 1 | Write pulse setting the power-down-enable bit |
| wake_ext_i | input | NUM_EXT | External wake interrupt lines |
| wake_tmr_i | input | 1 | Internal wake timer expiry |
| stat_clr_we_i | input | 1 | Write strobe for clearing the cause register |
| stat_clr_mask_i | input | NUM_EXT+1 | Ones mark cause bits to clear |
| lf_clk_en_o | output | 1 | Enable for the released 32 kHz system clock |
| ref_req_o | output | 1 | Request for the high-frequency reference from the radio |
| src_sel_hf_o | output | 1 | Clock source select, 1 = reference |
| pde_o | output | 1 | Power-down-enable bit |
| wake_stat_o | output | NUM_EXT+1 | Wake cause: bit 0 timer, bits above external lines |

## Verification
The assertions assume that all inputs are synchronous to `clk_lf`. They also assume that `rst_n` is the only asynchronous signal and that it is held low for at least one edge. The properties relate sleep entry, wake and cause capture to the port levels seen on the previous edge. For this reason, the stimulus changes every input only just after a falling edge. Random wake, clear, select and power-down pulses are drawn at low rates so that every state is visited many times. Directed sequences cover a capture colliding with a clear and a select level held high through sleep.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  typedef enum logic [2:0] {
    PM_RWAIT = 3'd0,
    PM_LF    = 3'd1,
    PM_HF    = 3'd2,
    PM_SLEEP = 3'd3,
    PM_WAKE  = 3'd4
  } pm_state_e;
endpackage

// File: rtl/slpwk_rst_sync.sv
module slpwk_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_n_sync <= stage1;
    end
  end
endmodule

// File: rtl/slpwk_tally.sv
// Counts cycles while run is high; done marks the LIMIT-th cycle.
module slpwk_tally #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)       cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slpwk_cause_reg.sv
// Wake cause register: bit 0 timer, bits N:1 external lines. Capture beats clear.
module slpwk_cause_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [N-1:0] ext,
  input  logic         tmr,
  input  logic         clr_we,
  input  logic [N:0]   clr_mask,
  output logic [N:0]   stat
);
  logic [N:0] stat_d;
  logic [N:0] keep;
  logic [N:0] cap;

  always_comb begin
    keep   = clr_we ? ~clr_mask : '1;
    cap    = cap_en ? {ext, tmr} : '0;
    stat_d = (stat & keep) | cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl #(
  parameter int NUM_EXT       = 4,
  parameter int STABLE_CYCLES = 4096,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic               clk_lf,
  input  logic               rst_n,
  input  logic               sel_hf_i,
  input  logic               pde_set_i,
  input  logic [NUM_EXT-1:0] wake_ext_i,
  input  logic               wake_tmr_i,
  input  logic               stat_clr_we_i,
  input  logic [NUM_EXT:0]   stat_clr_mask_i,
  output logic               lf_clk_en_o,
  output logic               ref_req_o,
  output logic               src_sel_hf_o,
  output logic               pde_o,
  output logic [NUM_EXT:0]   wake_stat_o
);
  import slpwk_pkg::*;

  logic      rst_n_i;
  pm_state_e st_q, st_d;
  logic      sel_q;
  logic      pde_q, pde_d;
  logic      stab_done, settle_done;
  logic      wake_any, sel_rise, in_run;

  slpwk_rst_sync u_rsync (
    .clk        (clk_lf),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_i)
  );

  slpwk_tally #(.LIMIT(STABLE_CYCLES)) u_stab (
    .clk  (clk_lf),
    .rst_n(rst_n_i),
    .run  (st_q == PM_RWAIT),
    .done (stab_done)
  );

  slpwk_tally #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk  (clk_lf),
    .rst_n(rst_n_i),
    .run  (st_q == PM_WAKE),
    .done (settle_done)
  );

  assign wake_any = wake_tmr_i | (|wake_ext_i);
  assign sel_rise = sel_hf_i & ~sel_q;
  assign in_run   = (st_q == PM_LF) || (st_q == PM_HF);

  slpwk_cause_reg #(.N(NUM_EXT)) u_cause (
    .clk     (clk_lf),
    .rst_n   (rst_n_i),
    .cap_en  ((st_q == PM_SLEEP) && wake_any),
    .ext     (wake_ext_i),
    .tmr     (wake_tmr_i),
    .clr_we  (stat_clr_we_i),
    .clr_mask(stat_clr_mask_i),
    .stat    (wake_stat_o)
  );

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RWAIT: if (stab_done) st_d = PM_LF;
      PM_LF: begin
        if (pde_q)         st_d = PM_SLEEP;
        else if (sel_rise) st_d = PM_HF;
      end
      PM_HF: begin
        if (pde_q)          st_d = PM_SLEEP;
        else if (!sel_hf_i) st_d = PM_LF;
      end
      PM_SLEEP: if (wake_any)    st_d = PM_WAKE;
      PM_WAKE:  if (settle_done) st_d = PM_LF;
      default:  st_d = PM_RWAIT;
    endcase
  end

  // Power-down-enable: cleared on sleep entry, set only in run states
  always_comb begin
    pde_d = pde_q;
    if (in_run && pde_q)          pde_d = 1'b0;
    else if (in_run && pde_set_i) pde_d = 1'b1;
  end

  always_ff @(posedge clk_lf or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= PM_RWAIT;
      sel_q <= 1'b0;
      pde_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_hf_i;
      pde_q <= pde_d;
    end
  end

  assign lf_clk_en_o  = (st_q != PM_RWAIT);
  assign ref_req_o    = in_run || (st_q == PM_WAKE);
  assign src_sel_hf_o = (st_q == PM_HF);
  assign pde_o        = pde_q;
endmodule

// File: rtl/slpwk_ctrl_chk.sv
module slpwk_ctrl_chk #(
  parameter int NUM_EXT = 4
) (
  input logic               clk_lf,
  input logic               rst_n,
  input logic [NUM_EXT-1:0] wake_ext_i,
  input logic               wake_tmr_i,
  input logic               lf_clk_en_o,
  input logic               ref_req_o,
  input logic               src_sel_hf_o,
  input logic               pde_o,
  input logic [NUM_EXT:0]   wake_stat_o
);
  assert_clk_stays_R2: assert property (@(posedge clk_lf) disable iff (!rst_n)
    !$fell(lf_clk_en_o));

  assert_sel_needs_ref_R3: assert property (@(posedge clk_lf) disable iff (!rst_n)
    src_sel_hf_o |-> ref_req_o);

  assert_hf_from_ref_R4: assert property (@(posedge clk_lf) disable iff (!rst_n)
    $rose(src_sel_hf_o) |-> $past(ref_req_o));

  assert_sleep_entry_R5: assert property (@(posedge clk_lf) disable iff (!rst_n)
    $fell(ref_req_o) |-> (!pde_o && !src_sel_hf_o && lf_clk_en_o));

  assert_wake_request_R6: assert property (@(posedge clk_lf) disable iff (!rst_n)
    (lf_clk_en_o && !ref_req_o && (wake_tmr_i || (|wake_ext_i))) |=> (ref_req_o && !src_sel_hf_o));

  assert_cause_in_sleep_R8: assert property (@(posedge clk_lf) disable iff (!rst_n)
    (|(wake_stat_o & ~$past(wake_stat_o))) |-> $past(lf_clk_en_o && !ref_req_o));

  assert_pde_in_run_R10: assert property (@(posedge clk_lf) disable iff (!rst_n)
    $rose(pde_o) |-> $past(ref_req_o && lf_clk_en_o));
endmodule

bind slpwk_ctrl slpwk_ctrl_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk_lf      (clk_lf),
  .rst_n       (rst_n),
  .wake_ext_i  (wake_ext_i),
  .wake_tmr_i  (wake_tmr_i),
  .lf_clk_en_o (lf_clk_en_o),
  .ref_req_o   (ref_req_o),
  .src_sel_hf_o(src_sel_hf_o),
  .pde_o       (pde_o),
  .wake_stat_o (wake_stat_o)
);

// File: tb/sim_slpwk_ctrl.sv
module sim_slpwk_ctrl;
  localparam int NE = 4;
  localparam int STAB = 40;
  localparam int SETTLE = 3;
  localparam int M_LF = 1, M_HF = 2, M_SL = 3, M_WK = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sel, pset, tmr, clr_we;
  logic [NE-1:0] ext;
  logic [NE:0] clr_mask;
  logic lf_en, ref_req, src_hf, pde;
  logic [NE:0] stat;

  int errors = 0;
  int checks = 0;
  int m_st, m_cnt;
  logic m_pde, m_selq;
  logic [NE:0] m_stat;

  always #10 clk = ~clk;

  slpwk_ctrl #(.NUM_EXT(NE), .STABLE_CYCLES(STAB), .SETTLE_CYCLES(SETTLE)) u0 (
    .clk_lf(clk), .rst_n(rst_n), .sel_hf_i(sel), .pde_set_i(pset),
    .wake_ext_i(ext), .wake_tmr_i(tmr), .stat_clr_we_i(clr_we),
    .stat_clr_mask_i(clr_mask), .lf_clk_en_o(lf_en), .ref_req_o(ref_req),
    .src_sel_hf_o(src_hf), .pde_o(pde), .wake_stat_o(stat));

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic exp_ref(int s);
    return (s == M_LF) || (s == M_HF) || (s == M_WK);
  endfunction

  // Reference model step from the requirements, applied at one edge.
  task automatic model_step();
    int ns = m_st;
    logic wk = tmr | (|ext);
    logic run = (m_st == M_LF) || (m_st == M_HF);
    logic [NE:0] keep = clr_we ? ~clr_mask : '1;
    logic [NE:0] cap = ((m_st == M_SL) && wk) ? {ext, tmr} : '0;
    case (m_st)
      M_LF: if (m_pde) ns = M_SL; else if (sel && !m_selq) ns = M_HF;
      M_HF: if (m_pde) ns = M_SL; else if (!sel) ns = M_LF;
      M_SL: if (wk) begin ns = M_WK; m_cnt = 0; end
      M_WK: if (m_cnt == SETTLE - 1) ns = M_LF; else m_cnt++;
      default: ;
    endcase
    if (run && m_pde) m_pde = 1'b0;
    else if (run && pset) m_pde = 1'b1;
    m_stat = (m_stat & keep) | cap;
    m_selq = sel;
    m_st = ns;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "lf_clk_en", lf_en, 1);
    chk(tag, "ref_req", ref_req, exp_ref(m_st));
    chk(tag, "src_sel_hf", src_hf, m_st == M_HF);
    chk(tag, "pde", pde, m_pde);
    chk(tag, "wake_stat", stat, m_stat);
  endtask

  task automatic idle_inputs();
    pset = 0; tmr = 0; ext = '0; clr_we = 0; clr_mask = '0;
  endtask

  initial begin
    #5_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first_hi;
    void'($urandom(32'd2024));
    rst_n = 0; sel = 0; idle_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "lf_clk_en", lf_en, 0);
    chk("R1", "ref_req", ref_req, 0);
    chk("R1", "src_sel_hf", src_hf, 0);
    chk("R1", "pde", pde, 0);
    chk("R1", "wake_stat", stat, 0);
    rst_n = 1;
    // R2 stabilisation delay, R10 pde_set ignored during the wait
    pset = 1;
    first_hi = 0;
    for (int k = 1; k <= STAB + 4 && first_hi == 0; k++) begin
      @(negedge clk);
      if (lf_en) first_hi = k;
      else chk("R3", "ref_req in wait", ref_req, 0);
    end
    chk("R2", "edges to clk release", first_hi, STAB + 2);
    chk("R10", "pde after wait", pde, 0);
    pset = 0;
    m_st = M_LF; m_cnt = 0; m_pde = 0; m_selq = 0; m_stat = '0;
    cyc("R3");

    // R4 select reference and back
    sel = 1; cyc("R4");
    chk("R4", "src_sel_hf after rise", src_hf, 1);
    cyc("R4");
    sel = 0; cyc("R4");
    chk("R4", "src_sel_hf after drop", src_hf, 0);

    // R5 sleep from HF, with select held high through sleep (R7)
    sel = 1; cyc("R4");
    pset = 1; cyc("R5");
    pset = 0;
    chk("R5", "pde set", pde, 1);
    cyc("R5");
    chk("R5", "ref_req in sleep", ref_req, 0);
    chk("R5", "pde cleared", pde, 0);
    // R8 wake input ignored outside sleep earlier; R10 pset ignored in sleep
    pset = 1; cyc("R10"); pset = 0;
    chk("R10", "pde in sleep", pde, 0);
    // R6 wake on ext[2], with a clear on the same bit (R9 capture wins)
    ext = 4'b0100; clr_we = 1; clr_mask = 5'b01000;
    cyc("R6");
    idle_inputs();
    chk("R6", "ref_req on wake", ref_req, 1);
    chk("R8", "cause ext2 -> bit3", stat, 5'b01000);
    chk("R9", "capture beats clear", stat[3], 1);
    // R10 pset ignored in wake settle
    pset = 1; cyc("R10"); pset = 0;
    repeat (SETTLE + 2) cyc("R7");
    chk("R7", "no reselect on held level", src_hf, 0);
    chk("R10", "pde after wake", pde, 0);
    sel = 0; cyc("R7");
    sel = 1; cyc("R7");
    chk("R7", "reselect on new rise", src_hf, 1);
    // R8 wake inputs outside sleep ignored
    tmr = 1; ext = 4'b1111; cyc("R8"); idle_inputs();
    chk("R8", "no capture while running", stat, 5'b01000);
    // R9 partial clear
    clr_we = 1; clr_mask = 5'b00001; cyc("R9"); idle_inputs();
    chk("R9", "unmasked bit kept", stat, 5'b01000);
    clr_we = 1; clr_mask = 5'b01000; cyc("R9"); idle_inputs();
    chk("R9", "masked bit cleared", stat, 5'b00000);
    // R6 timer wake with priority of pde over select drop (R5)
    pset = 1; cyc("R5"); pset = 0;
    sel = 0; cyc("R5");
    chk("R5", "sleep over select", ref_req, 0);
    tmr = 1; cyc("R6"); idle_inputs();
    chk("R8", "timer cause bit0", stat, 5'b00001);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) sel = ~sel;
      pset = ($urandom_range(15) == 0);
      tmr  = ($urandom_range(29) == 0);
      for (int b = 0; b < NE; b++) ext[b] = ($urandom_range(39) == 0);
      clr_we = ($urandom_range(7) == 0);
      clr_mask = 5'($urandom);
      cyc("R3");
    end
    idle_inputs();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule